// File: doc/BRIEF.md
# SPI NOR Command Frame Engine

This block turns a one-shot operation request into a complete single-lane SPI NOR frame. The requester presents an operation code, a flash address, a byte count and an address-width flag together with a one-cycle `start`. The engine then lowers chip select and plays a fixed list of steps for that operation: a command byte, an address of three or four bytes, eight dummy clocks, read data or write data. It ends by raising chip select. Write data is pulled from a valid/ready byte stream. Read data is pushed onto a second valid/ready byte stream.

The serial side runs in SPI mode 0, most significant bit first. SCLK idles low, and MISO is sampled on the rising edge. SCLK has a period of `2*HALF_DIV` system clocks. Stream back-pressure stretches the SCLK low time without corrupting the frame. `done` pulses in the cycle chip select is released. Chip select then stays high for at least one SCLK period before the next frame can begin.

The controller has six states. IDLE waits for `start`. LOAD picks the next step and the next byte. TXWAIT waits for a write byte. SHIFT moves eight bits. RXHOLD offers a received byte. GAP holds chip select high. The transitions are:
- IDLE to LOAD on start.
- LOAD to LOAD when a step is exhausted.
- LOAD to TXWAIT for a write byte.
- LOAD to SHIFT for any other byte.
- LOAD to GAP on the stop step.
- TXWAIT to SHIFT on tx_valid.
- SHIFT to LOAD after the eighth bit, or SHIFT to RXHOLD after the eighth bit of a read byte.
- RXHOLD to LOAD on rx_ready.
- GAP to IDLE after one SCLK period.

Top module: `snf_engine`

## Requirements
- R1: While and after reset, with no request, `cs_n` is 1 and `sclk`, `busy`, `done`, `tx_ready` and `rx_valid` are 0.
- R2: The `op` input selects the operation: 0 read, 1 fast read, 2 page program, 3 write enable, 4 64 KB erase, 5 4 KB erase, 6 bulk erase, 7 read status. The first byte shifted out is the command code for that operation.
  - With `addr4`=0, the codes are 03h, 0Bh, 02h, 06h, D8h, 20h, C7h and 05h in that order.
  - With `addr4`=1, the codes are 13h, 0Ch, 12h, 06h, DCh, 21h, C7h and 05h.
- R3: Read, fast read, program and both erases send the address right after the command, most significant byte first. They send `addr[23:0]` as three bytes when `addr4`=0 and `addr[31:0]` as four bytes when `addr4`=1. Write enable, bulk erase and read status send no address.
- R4: Fast read inserts exactly 8 SCLK cycles between the address and the data. MOSI is low during those cycles.
- R5: Read and fast read return exactly `len` bytes on the receive stream. Each byte is built from MISO bits sampled on rising SCLK, first bit in bit 7. Read status returns exactly one byte whatever `len` is. A read with `len`=0 ends after its address.
- R6: Page program takes exactly `len` bytes from the transmit stream and shifts them out after the address, most significant bit first. `tx_ready` is 1 only while chip select is low and SCLK is low.
- R7: Write enable, both erases and bulk erase end right after their command and address bytes, and `len` has no effect on them.
- R8: SCLK is low whenever `cs_n` is 1. Each SCLK high phase lasts `HALF_DIV` clocks. MOSI does not change while SCLK is high.
- R9: `done` is a one-cycle pulse in exactly the cycle in which `cs_n` rises. `busy` is 1 whenever `cs_n` is 0.
- R10: Between two frames, `cs_n` stays high for at least `2*HALF_DIV` clock cycles.
- R11: A `start` while `busy` is 1 is ignored. It neither alters the running frame nor queues another.
- R12: While `tx_valid` or `rx_ready` holds the engine back, SCLK stays low with chip select low and no byte is lost. `rx_data` stays stable while `rx_valid` is 1 and `rx_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a frame |
| op | input | 3 | Operation select (encoding in R2) |
| addr | input | 32 | Flash byte address |
| len | input | LEN_W | Data byte count for read and program |
| addr4 | input | 1 | 1 selects four-byte addressing and the wide command codes |
| busy | output | 1 | Frame in progress, including the closing gap |
| done | output | 1 | Pulse when chip select is released |
| tx_data | input | 8 | Write byte |
| tx_valid | input | 1 | Write byte available |
| tx_ready | output | 1 | Engine accepts a write byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer accepts the received byte |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
Two things can land in the same cycle here: a new `start` and the closing of the previous frame, including the cycle `done` pulses. The bench provokes this in two ways. First, it raises `start` in the very cycle `done` is seen and holds it there. It judges the result by counting the high cycles of `cs_n` and by the content of the following frame. Second, it pulses `start` with a different operation in the middle of a read. It then confirms that the read's command, clock count and data are unchanged and that no second frame follows. Receive back-pressure is made to coincide with the completion of a byte by toggling `rx_ready` and `tx_valid` on a fixed cycle pattern. The bench checks that every byte still arrives in order and with the value the flash model drove.

// File: rtl/snf_pkg.sv
package snf_pkg;

    localparam int ADDR_W = 32;
    localparam int STEP_W = 3;

    typedef enum logic [2:0] {
        OP_READ    = 3'd0,
        OP_FREAD   = 3'd1,
        OP_PROG    = 3'd2,
        OP_WREN    = 3'd3,
        OP_ERASE64 = 3'd4,
        OP_ERASE4  = 3'd5,
        OP_BULK    = 3'd6,
        OP_STATUS  = 3'd7
    } snf_op_e;

    typedef enum logic [2:0] {
        ST_CMD, ST_ADDR, ST_DUMMY, ST_RD, ST_WR, ST_STOP
    } snf_step_e;

    // Fixed step list of each operation; every index past the list is a stop.
    function automatic snf_step_e step_at(snf_op_e op, logic [STEP_W-1:0] idx);
        snf_step_e s;
        s = ST_STOP;
        if (idx == 3'd0) begin
            s = ST_CMD;
        end else begin
            case (op)
                OP_READ:    if (idx == 3'd1) s = ST_ADDR; else if (idx == 3'd2) s = ST_RD;
                OP_FREAD:   if (idx == 3'd1) s = ST_ADDR; else if (idx == 3'd2) s = ST_DUMMY;
                            else if (idx == 3'd3) s = ST_RD;
                OP_PROG:    if (idx == 3'd1) s = ST_ADDR; else if (idx == 3'd2) s = ST_WR;
                OP_ERASE64,
                OP_ERASE4:  if (idx == 3'd1) s = ST_ADDR;
                OP_STATUS:  if (idx == 3'd1) s = ST_RD;
                default:    s = ST_STOP;
            endcase
        end
        return s;
    endfunction

    function automatic logic [7:0] op_code(snf_op_e op, logic wide);
        logic [7:0] c;
        case (op)
            OP_READ:    c = wide ? 8'h13 : 8'h03;
            OP_FREAD:   c = wide ? 8'h0C : 8'h0B;
            OP_PROG:    c = wide ? 8'h12 : 8'h02;
            OP_WREN:    c = 8'h06;
            OP_ERASE64: c = wide ? 8'hDC : 8'hD8;
            OP_ERASE4:  c = wide ? 8'h21 : 8'h20;
            OP_BULK:    c = 8'hC7;
            default:    c = 8'h05;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/snf_bit_timer.sv
module snf_bit_timer #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk_lvl,
    output logic rise_tick,
    output logic end_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_q;
    logic          phase_q;
    logic          at_end;

    assign at_end = run && (cnt_q == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (at_end) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q   <= cnt_q + CW'(1);
        end
    end

    assign sclk_lvl  = phase_q;
    assign rise_tick = at_end && !phase_q;
    assign end_tick  = at_end && phase_q;
endmodule

// File: rtl/snf_shifter.sv
module snf_shifter #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [BW-1:0] load_val,
    input  logic          shift,
    input  logic          sample,
    input  logic          miso,
    output logic          mosi,
    output logic [BW-1:0] rx_byte
);
    logic [BW-1:0] out_q;
    logic [BW-1:0] in_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            in_q  <= '0;
        end else begin
            if (load)
                out_q <= load_val;
            else if (shift)
                out_q <= {out_q[BW-2:0], 1'b0};
            if (sample)
                in_q <= {in_q[BW-2:0], miso};
        end
    end

    assign mosi    = out_q[BW-1];
    assign rx_byte = in_q;
endmodule

// File: rtl/snf_engine.sv
module snf_engine
    import snf_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int LEN_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic [31:0]      addr,
    input  logic [LEN_W-1:0] len,
    input  logic             addr4,
    output logic             busy,
    output logic             done,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    input  logic             rx_ready,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso
);
    typedef enum logic [2:0] {
        S_IDLE, S_LOAD, S_TXWAIT, S_SHIFT, S_RXHOLD, S_GAP
    } state_e;

    state_e              state_q, state_d;
    snf_op_e             op_q;
    logic                wide_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [LEN_W-1:0]    len_q;
    logic [STEP_W-1:0]   step_q;
    logic [LEN_W-1:0]    byte_q;
    logic [2:0]          bit_q;
    logic                done_q;
    logic [7:0]          rxd_q;

    snf_step_e           cur_step;
    logic [LEN_W-1:0]    step_cnt;
    logic                step_done;
    logic [1:0]          addr_sel;
    logic [7:0]          addr_byte;
    logic [7:0]          load_val;
    logic                sh_load;
    logic                last_bit;
    logic                sclk_lvl, rise_tick, end_tick, rx_bit_mosi;
    logic [7:0]          rx_byte;

    // Step bookkeeping
    assign cur_step = step_at(op_q, step_q);

    always_comb begin
        case (cur_step)
            ST_CMD:   step_cnt = LEN_W'(1);
            ST_ADDR:  step_cnt = wide_q ? LEN_W'(4) : LEN_W'(3);
            ST_DUMMY: step_cnt = LEN_W'(1);
            ST_RD:    step_cnt = (op_q == OP_STATUS) ? LEN_W'(1) : len_q;
            ST_WR:    step_cnt = len_q;
            default:  step_cnt = '0;
        endcase
    end

    assign step_done = (byte_q == step_cnt);
    assign addr_sel  = (wide_q ? 2'd3 : 2'd2) - byte_q[1:0];
    assign addr_byte = addr_q[{addr_sel, 3'b000} +: 8];
    assign last_bit  = end_tick && (bit_q == 3'd7);

    always_comb begin
        load_val = 8'h00;
        if (state_q == S_TXWAIT)
            load_val = tx_data;
        else if (cur_step == ST_CMD)
            load_val = op_code(op_q, wide_q);
        else if (cur_step == ST_ADDR)
            load_val = addr_byte;
    end

    assign sh_load = ((state_q == S_LOAD) && (cur_step != ST_STOP) && !step_done
                      && (cur_step != ST_WR))
                   || ((state_q == S_TXWAIT) && tx_valid);

    snf_bit_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       ((state_q == S_SHIFT) || (state_q == S_GAP)),
        .sclk_lvl  (sclk_lvl),
        .rise_tick (rise_tick),
        .end_tick  (end_tick)
    );

    snf_shifter #(.BW(8)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (load_val),
        .shift    (end_tick && (state_q == S_SHIFT)),
        .sample   (rise_tick && (state_q == S_SHIFT)),
        .miso     (miso),
        .mosi     (rx_bit_mosi),
        .rx_byte  (rx_byte)
    );

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_LOAD;
            S_LOAD: begin
                if (cur_step == ST_STOP)    state_d = S_GAP;
                else if (step_done)         state_d = S_LOAD;
                else if (cur_step == ST_WR) state_d = S_TXWAIT;
                else                        state_d = S_SHIFT;
            end
            S_TXWAIT: if (tx_valid) state_d = S_SHIFT;
            S_SHIFT:  if (last_bit) state_d = (cur_step == ST_RD) ? S_RXHOLD : S_LOAD;
            S_RXHOLD: if (rx_ready) state_d = S_LOAD;
            S_GAP:    if (end_tick) state_d = S_IDLE;
        endcase
    end

    // State register and frame datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_READ;
            wide_q  <= 1'b0;
            addr_q  <= '0;
            len_q   <= '0;
            step_q  <= '0;
            byte_q  <= '0;
            bit_q   <= '0;
            done_q  <= 1'b0;
            rxd_q   <= '0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == S_LOAD) && (cur_step == ST_STOP);
            unique case (state_q)
                S_IDLE: if (start) begin
                    op_q   <= snf_op_e'(op);
                    wide_q <= addr4;
                    addr_q <= addr;
                    len_q  <= len;
                    step_q <= '0;
                    byte_q <= '0;
                    bit_q  <= '0;
                end
                S_LOAD: if (cur_step != ST_STOP && step_done) begin
                    step_q <= step_q + STEP_W'(1);
                    byte_q <= '0;
                end
                S_SHIFT: if (end_tick) begin
                    bit_q <= bit_q + 3'd1;
                    if (bit_q == 3'd7) begin
                        byte_q <= byte_q + LEN_W'(1);
                        if (cur_step == ST_RD) rxd_q <= rx_byte;
                    end
                end
                S_TXWAIT, S_RXHOLD, S_GAP: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        cs_n     = (state_q == S_IDLE) || (state_q == S_GAP);
        sclk     = (state_q == S_SHIFT) && sclk_lvl;
        mosi     = rx_bit_mosi;
        busy     = (state_q != S_IDLE);
        done     = done_q;
        tx_ready = (state_q == S_TXWAIT);
        rx_valid = (state_q == S_RXHOLD);
        rx_data  = rxd_q;
    end
endmodule

// File: rtl/snf_engine_chk.sv
module snf_engine_chk #(
    parameter int HALF_DIV = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       tx_ready,
    input logic [7:0] rx_data,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic       sclk,
    input logic       cs_n,
    input logic       mosi
);
    localparam int GAP = 2 * HALF_DIV;

    logic [15:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_cnt <= 16'(GAP);
        else if (!cs_n)
            gap_cnt <= '0;
        else if (gap_cnt < 16'(GAP))
            gap_cnt <= gap_cnt + 16'd1;
    end

    AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);                                                   // R8
    AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));                          // R8
    AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(cs_n));                                             // R9
    AST_RELEASE_SIGNALLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> done);                                             // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                   // R9
    AST_BUSY_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);                                                   // R9
    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (gap_cnt >= 16'(GAP)));                            // R10
    AST_TX_READY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (!cs_n && !sclk));                                    // R6
    AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));       // R12
    AST_RX_STALL_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (!sclk && !cs_n));                                    // R12
endmodule

bind snf_engine snf_engine_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .tx_ready (tx_ready),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .mosi     (mosi)
);

// File: tb/sim_snf_engine.sv
module sim_snf_engine;
    localparam int HALF = 2;
    localparam int NV   = 15;

    typedef struct packed {
        logic [2:0]  op;
        logic        a4;
        logic [31:0] addr;
        logic [15:0] len;
        logic [7:0]  opc;
        logic [3:0]  hdr;
        logic [7:0]  dat;
        logic        slow;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{3'd0, 1'b0, 32'hFF123456, 16'd3, 8'h03, 4'd4, 8'd3, 1'b0},
        '{3'd0, 1'b1, 32'h89ABCDEF, 16'd2, 8'h13, 4'd5, 8'd2, 1'b1},
        '{3'd1, 1'b0, 32'h0000ABCD, 16'd2, 8'h0B, 4'd5, 8'd2, 1'b0},
        '{3'd1, 1'b1, 32'h01020304, 16'd1, 8'h0C, 4'd6, 8'd1, 1'b1},
        '{3'd2, 1'b0, 32'h00000100, 16'd3, 8'h02, 4'd4, 8'd3, 1'b0},
        '{3'd2, 1'b1, 32'h10000200, 16'd2, 8'h12, 4'd5, 8'd2, 1'b1},
        '{3'd3, 1'b1, 32'h00000055, 16'd5, 8'h06, 4'd1, 8'd0, 1'b0},
        '{3'd4, 1'b0, 32'h00010000, 16'd0, 8'hD8, 4'd4, 8'd0, 1'b0},
        '{3'd4, 1'b1, 32'h02010000, 16'd0, 8'hDC, 4'd5, 8'd0, 1'b0},
        '{3'd5, 1'b0, 32'h00001000, 16'd4, 8'h20, 4'd4, 8'd0, 1'b0},
        '{3'd5, 1'b1, 32'h00002000, 16'd9, 8'h21, 4'd5, 8'd0, 1'b0},
        '{3'd6, 1'b1, 32'h12345678, 16'd3, 8'hC7, 4'd1, 8'd0, 1'b0},
        '{3'd7, 1'b1, 32'h00000040, 16'd7, 8'h05, 4'd1, 8'd1, 1'b1},
        '{3'd0, 1'b0, 32'h00000200, 16'd0, 8'h03, 4'd4, 8'd0, 1'b0},
        '{3'd7, 1'b0, 32'h00000000, 16'd0, 8'h05, 4'd1, 8'd1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n, start, addr4, tx_valid, rx_ready, miso;
    logic [2:0]  op_i;
    logic [31:0] addr_i;
    logic [15:0] len_i;
    logic [7:0]  tx_data, rx_data;
    logic        busy, done, tx_ready, rx_valid, sclk, cs_n, mosi;

    always #2 clk = ~clk;

    snf_engine #(.HALF_DIV(HALF), .LEN_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .addr(addr_i),
        .len(len_i), .addr4(addr4), .busy(busy), .done(done),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    // Flash model: logs MOSI bytes, drives a known byte pattern on MISO
    int         rise_n = 0, fall_n = 0, rbase = 0, fbase = 0;
    logic [7:0] mo_sh = 8'h00;
    logic [7:0] mo_bytes [32];

    function automatic logic [7:0] rbyte(int p);
        return 8'(8'h5A ^ (p * 29));
    endfunction

    function automatic logic mbit(int k);
        logic [7:0] b;
        b = rbyte(k / 8);
        return b[7 - (k % 8)];
    endfunction

    always @(negedge cs_n) begin
        rbase = rise_n;
        fbase = fall_n;
    end
    always @(posedge sclk) begin
        mo_sh  = {mo_sh[6:0], mosi};
        rise_n = rise_n + 1;
        if (((rise_n - rbase) % 8) == 0 && (rise_n - rbase) / 8 <= 32)
            mo_bytes[(rise_n - rbase) / 8 - 1] = mo_sh;
    end
    always @(negedge sclk) fall_n = fall_n + 1;
    assign miso = mbit(fall_n - fbase);

    int         nchk = 0, nerr = 0;
    int         tx_n, rx_n, ndone, hi_bad;
    logic [7:0] rx_got [16];

    task automatic chk(input string r, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic run_frame(input logic [2:0] o, input logic a4, input logic [31:0] ad,
                             input logic [15:0] ln, input logic slow, input logic poke);
        bit fin, pend;
        int hi;
        while (busy) @(negedge clk);
        @(negedge clk);
        op_i = o; addr4 = a4; addr_i = ad; len_i = ln; start = 1'b1;
        tx_n = 0; rx_n = 0; ndone = 0; hi_bad = 0; hi = 0; fin = 0; pend = 0;
        tx_valid = 1'b1; rx_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 4000 && !fin; c++) begin
            @(negedge clk);
            if (pend) begin tx_n++; pend = 0; end
            tx_data = 8'(8'hC0 + tx_n);
            if (slow) begin
                tx_valid = (c % 3 == 0);
                rx_ready = (c % 4 == 0);
            end
            if (poke && c == 20) begin start = 1'b1; op_i = 3'd6; end
            if (poke && c == 21) start = 1'b0;
            if (tx_valid && tx_ready) pend = 1;
            if (rx_valid && rx_ready) begin
                if (rx_n < 16) rx_got[rx_n] = rx_data;
                rx_n++;
            end
            if (sclk) hi++;
            else begin
                if (hi != 0 && hi != HALF) hi_bad = 1;
                hi = 0;
            end
            if (done) begin ndone++; fin = 1; end
        end
        tx_valid = 1'b0; rx_ready = 1'b0;
    endtask

    function automatic string clk_req(logic [2:0] o);
        case (o)
            3'd0, 3'd7: return "R5 frame length";
            3'd1:       return "R4 frame length";
            3'd2:       return "R6 frame length";
            default:    return "R7 frame length";
        endcase
    endfunction

    task automatic check_vec(input vec_t v);
        bit addressed;
        int nab;
        addressed = (v.op == 3'd0 || v.op == 3'd1 || v.op == 3'd2 || v.op == 3'd4 || v.op == 3'd5);
        nab = addressed ? (v.a4 ? 4 : 3) : 0;
        chk("R2 command code", mo_bytes[0], v.opc);
        chk(clk_req(v.op), rise_n - rbase, 8 * (int'(v.hdr) + int'(v.dat)));
        for (int i = 0; i < nab; i++)
            chk("R3 address byte", mo_bytes[1 + i], 8'(v.addr >> (8 * (nab - 1 - i))));
        if (v.op == 3'd1) chk("R4 dummy low", mo_bytes[1 + nab], 0);
        if (v.op == 3'd0 || v.op == 3'd1 || v.op == 3'd7) begin
            chk("R5 rx count", rx_n, v.dat);
            for (int i = 0; i < int'(v.dat); i++)
                chk(v.slow ? "R12 rx byte" : "R5 rx byte", rx_got[i], rbyte(int'(v.hdr) + i));
        end
        if (v.op == 3'd2) begin
            chk("R6 tx count", tx_n, v.dat);
            for (int i = 0; i < int'(v.dat); i++)
                chk(v.slow ? "R12 tx byte" : "R6 tx byte", mo_bytes[int'(v.hdr) + i], 8'hC0 + i);
        end
        chk("R9 done seen", ndone, 1);
        chk("R8 sclk high time", hi_bad, 0);
    endtask

    initial begin
        bit wd;
        wd = 0;
        rst_n = 0; start = 0; op_i = 0; addr_i = 0; len_i = 0; addr4 = 0;
        tx_data = 0; tx_valid = 0; rx_ready = 0;
        fork
            begin
                repeat (4) @(negedge clk);
                chk("R1 cs_n in reset", cs_n, 1);
                chk("R1 sclk in reset", sclk, 0);
                rst_n = 1;
                @(negedge clk);
                chk("R1 idle outputs", {busy, done, tx_ready, rx_valid, sclk}, 0);
                chk("R1 idle cs_n", cs_n, 1);

                // Vector table
                for (int i = 0; i < NV; i++) begin
                    run_frame(VEC[i].op, VEC[i].a4, VEC[i].addr, VEC[i].len, VEC[i].slow, 1'b0);
                    check_vec(VEC[i]);
                end

                // R11: start during a read is ignored
                begin
                    int rn;
                    run_frame(3'd0, 1'b1, 32'hA1B2C3D4, 16'd1, 1'b0, 1'b1);
                    chk("R11 command kept", mo_bytes[0], 8'h13);
                    chk("R11 length kept", rise_n - rbase, 8 * 6);
                    chk("R11 data kept", rx_got[0], rbyte(5));
                    rn = rise_n;
                    repeat (40) @(negedge clk);
                    chk("R11 no queued frame", rise_n - rn, 0);
                    chk("R11 idle after", busy, 0);
                end

                // R10: start held from the done cycle
                begin
                    int g;
                    run_frame(3'd3, 1'b0, 32'h0, 16'd0, 1'b0, 1'b0);
                    g = 1;
                    op_i = 3'd6; start = 1'b1;
                    for (int c = 0; c < 100; c++) begin
                        @(negedge clk);
                        if (cs_n) g++;
                        else break;
                    end
                    start = 1'b0;
                    chk("R10 deselect gap", int'(g >= 2 * HALF), 1);
                    for (int c = 0; c < 400 && !done; c++) @(negedge clk);
                    chk("R10 following frame command", mo_bytes[0], 8'hC7);
                end
            end
            begin
                repeat (150000) @(posedge clk);
                wd = 1;
            end
        join_any
        disable fork;
        if (wd) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual expired expected finished");
        end
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule